// File: doc/BRIEF.md
# Secure FPU access gating registers

This block keeps three system control registers and works out where a floating-point instruction has to trap. The three registers are a coprocessor access register, a hypervisor trap register and a secure-owned gate register. A single bit in the gate register lets secure software lock the floating-point unit away from the non-secure world. While the lock is active, the fields in the other two registers that govern floating-point access show fixed values to non-secure accesses. Non-secure writes to those fields are dropped. The stored contents stay untouched underneath.

The lock only counts when three things are true: a secure monitor level is fitted, that level runs in 32-bit mode, and the access is non-secure. Two strap inputs describe the monitor level. The trap-target output gives the exception level that takes a blocked floating-point instruction. When the lock is not tripping, the output passes on a trap level that the surrounding checks compute.

Top module: `fpu_gate_regs`

## Requirements
- R1: The lock is in force only when `mon_present`=1, `mon_is_64`=0 and the access is non-secure. With the monitor absent or 64-bit, the gate bit changes neither read data nor the trap output.
- R2: Bit 10 of the gate register (select 2) controls the lock. A 0 blocks non-secure floating-point use and a 1 permits it.
- R3: While locked, a read of the access register (select 0) returns bits 23:20 as zero, whatever is stored there.
- R4: While locked, a write to the access register stores every bit except 23:20, which keep their old value.
- R5: While locked, a read of the hypervisor trap register (select 1) returns bits 11:10 as ones.
- R6: While locked, a write to the hypervisor trap register stores every bit except 11:10, which keep their old value.
- R7: After a synchronous active-low reset, all three registers hold zero, so the lock is active. Select 3 always reads zero.
- R8: `trap_lvl` uses 0 for no trap. A floating-point instruction is blocked when R1 holds, the level is 2 or lower, `sec_ns`=1 and the gate bit is 0. The target is 2 at level 2 and 1 at levels 0 and 1.
- R9: A lock trap overrides `base_trap_lvl`. In every other case `trap_lvl` equals `base_trap_lvl`.
- R10: An access is secure when `sec_ns`=0 or `cur_lvl`=3. Secure reads and writes see and update the full stored value.
- R11: Masked fields keep their stored contents. Setting the gate bit makes them visible again to non-secure reads.
- R12: Reads are combinational from `rd_sel`. A write lands on the clock edge where `wr_en`=1, using the security state of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select (0 access, 1 hyp trap, 2 gate) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data as seen by the current access |
| cur_lvl | input | 2 | Current exception level 0..3 |
| sec_ns | input | 1 | 1 when the world below the monitor is non-secure |
| mon_present | input | 1 | Strap: a secure monitor level exists |
| mon_is_64 | input | 1 | Strap: the monitor level runs 64-bit |
| base_trap_lvl | input | 2 | Trap target from the other access checks, 0 for none |
| trap_lvl | output | 2 | Resolved floating-point trap target, 0 for none |

## Verification
The assertions assume that the strap inputs, the level and the security state are stable across any cycle in which a write is sampled. They also assume that `cur_lvl` and `base_trap_lvl` carry legal encodings. The bench changes inputs only on falling edges and pulses `wr_en` for exactly one rising edge. It moves straps and levels only while no write is pending, so each write sees one consistent security view.

// File: rtl/fgr_pkg.sv
// Shared definitions for the FPU gating register block.
// Assumes a 32-bit register view. The masked field positions are
// architectural and fixed, so they are not parameters.
package fgr_pkg;
    localparam int unsigned REG_W = 32;

    typedef enum logic [1:0] {
        SEL_ACC  = 2'd0,
        SEL_HYP  = 2'd1,
        SEL_GATE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned GATE_BIT = 10;
    localparam logic [REG_W-1:0] ACC_FP_MASK = 32'h00F0_0000;
    localparam logic [REG_W-1:0] HYP_FP_MASK = 32'h0000_0C00;
    localparam logic [1:0] LVL_NONE = 2'd0;
    localparam logic [1:0] LVL_ONE  = 2'd1;
    localparam logic [1:0] LVL_TWO  = 2'd2;
    localparam logic [1:0] LVL_MON  = 2'd3;
endpackage

// File: rtl/fgr_gate_cond.sv
// Decides whether the access is non-secure and whether the gate can apply.
// Assumes that level 3 is always secure and that the straps are static.
module fgr_gate_cond
    import fgr_pkg::*;
(
    input  logic       mon_present,
    input  logic       mon_is_64,
    input  logic       sec_ns,
    input  logic [1:0] cur_lvl,
    input  logic       gate_bit,
    output logic       ns_access,
    output logic       regs_locked,
    output logic       fp_block
);
    logic gate_env;

    // Combine the straps, the security state and the gate bit into lock flags.
    always_comb begin
        ns_access   = sec_ns && (cur_lvl != LVL_MON);
        gate_env    = mon_present && !mon_is_64;
        regs_locked = gate_env && ns_access && !gate_bit;
        fp_block    = gate_env && sec_ns && (cur_lvl <= LVL_TWO) && !gate_bit;
    end
endmodule

// File: rtl/fgr_field_reg.sv
// One control register with a field that the lock protects.
// When the lock is active, writes keep the old field value. Reads show
// either zeros or ones in the field, as FORCE_ONES selects.
// Assumes that `locked` is valid in the same cycle as `we`.
module fgr_field_reg #(
    parameter int unsigned    W          = 32,
    parameter logic [W-1:0]   FIELD_MASK = '0,
    parameter bit             FORCE_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         locked,
    input  logic [W-1:0] wd,
    output logic [W-1:0] view,
    output logic [W-1:0] raw
);
    logic [W-1:0] q;
    logic [W-1:0] next_val;
    logic [W-1:0] kept;

    // Merge the write data with the protected field while locked.
    always_comb begin
        kept     = (wd & ~FIELD_MASK) | (q & FIELD_MASK);
        next_val = locked ? kept : wd;
    end

    // Storage with synchronous active-low reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= next_val;
    end

    // Presented value: apply the forced field pattern while locked.
    generate
        if (FORCE_ONES) begin : g_force_one
            always_comb view = locked ? (q | FIELD_MASK) : q;
        end else begin : g_force_zero
            always_comb view = locked ? (q & ~FIELD_MASK) : q;
        end
    endgenerate

    assign raw = q;

    // R4 and R6: a locked write leaves the protected field unchanged.
    p_field_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && locked) |=> ((q & FIELD_MASK) == ($past(q) & FIELD_MASK)));

    // R12 and R10: an unlocked write lands in full on the next edge.
    p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !locked) |=> (q == $past(wd)));

    // The unprotected bits always take the written data.
    p_free_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q & ~FIELD_MASK) == ($past(wd) & ~FIELD_MASK)));

    // Without a write the register holds its value.
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/fgr_trap_sel.sv
// Resolves the floating-point trap target. The lock trap wins over the
// merged target from the other checks. Assumes cur_lvl <= 2 when fp_block.
module fgr_trap_sel
    import fgr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fp_block,
    input  logic [1:0] cur_lvl,
    input  logic [1:0] base_trap_lvl,
    output logic [1:0] trap_lvl
);
    // Choose the lock target by the current level, or pass the merge input on.
    always_comb begin
        if (fp_block) trap_lvl = (cur_lvl == LVL_TWO) ? LVL_TWO : LVL_ONE;
        else          trap_lvl = base_trap_lvl;
    end

    // R8: a lock trap never reports "no trap" and never targets the monitor.
    p_block_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fp_block |-> (trap_lvl == LVL_ONE || trap_lvl == LVL_TWO));

    // R9: without a lock trap the merge input passes through.
    p_pass_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_block |-> (trap_lvl == base_trap_lvl));
endmodule

// File: rtl/fpu_gate_regs.sv
// Top level: the three control registers, the read mux and the FP trap target.
// Assumes that the straps are static during operation and that the write
// security state is presented in the same cycle as wr_en.
module fpu_gate_regs
    import fgr_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        cur_lvl,
    input  logic              sec_ns,
    input  logic              mon_present,
    input  logic              mon_is_64,
    input  logic [1:0]        base_trap_lvl,
    output logic [1:0]        trap_lvl
);
    localparam logic [DATA_W-1:0] ACC_MASK = DATA_W'(ACC_FP_MASK);
    localparam logic [DATA_W-1:0] HYP_MASK = DATA_W'(HYP_FP_MASK);

    logic              ns_access;
    logic              regs_locked;
    logic              fp_block;
    logic [DATA_W-1:0] acc_view, acc_raw;
    logic [DATA_W-1:0] hyp_view, hyp_raw;
    logic [DATA_W-1:0] gate_view, gate_raw;
    logic              we_acc, we_hyp, we_gate;

    // Decode the write select into one strobe per register.
    always_comb begin
        we_acc  = wr_en && (reg_sel_e'(wr_sel) == SEL_ACC);
        we_hyp  = wr_en && (reg_sel_e'(wr_sel) == SEL_HYP);
        we_gate = wr_en && (reg_sel_e'(wr_sel) == SEL_GATE);
    end

    fgr_gate_cond u_cond (
        .mon_present (mon_present),
        .mon_is_64   (mon_is_64),
        .sec_ns      (sec_ns),
        .cur_lvl     (cur_lvl),
        .gate_bit    (gate_raw[GATE_BIT]),
        .ns_access   (ns_access),
        .regs_locked (regs_locked),
        .fp_block    (fp_block)
    );

    fgr_field_reg #(.W(DATA_W), .FIELD_MASK(ACC_MASK), .FORCE_ONES(1'b0)) u_acc (
        .clk (clk), .rst_n (rst_n), .we (we_acc), .locked (regs_locked),
        .wd (wr_data), .view (acc_view), .raw (acc_raw)
    );

    fgr_field_reg #(.W(DATA_W), .FIELD_MASK(HYP_MASK), .FORCE_ONES(1'b1)) u_hyp (
        .clk (clk), .rst_n (rst_n), .we (we_hyp), .locked (regs_locked),
        .wd (wr_data), .view (hyp_view), .raw (hyp_raw)
    );

    fgr_field_reg #(.W(DATA_W), .FIELD_MASK('0), .FORCE_ONES(1'b0)) u_gate (
        .clk (clk), .rst_n (rst_n), .we (we_gate), .locked (regs_locked),
        .wd (wr_data), .view (gate_view), .raw (gate_raw)
    );

    fgr_trap_sel u_trap (
        .clk           (clk),
        .rst_n         (rst_n),
        .fp_block      (fp_block),
        .cur_lvl       (cur_lvl),
        .base_trap_lvl (base_trap_lvl),
        .trap_lvl      (trap_lvl)
    );

    // Combinational read mux; select 3 reads as zero.
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_ACC:  rd_data = acc_view;
            SEL_HYP:  rd_data = hyp_view;
            SEL_GATE: rd_data = gate_view;
            default:  rd_data = '0;
        endcase
    end

    // R1: with the monitor absent or 64-bit, the trap output is the merge input.
    p_strap_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_present || mon_is_64) |-> (trap_lvl == base_trap_lvl));

    // R10: a secure read of the access register returns the stored bits.
    p_secure_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ns_access && rd_sel == 2'd0) |-> (rd_data == acc_raw));

    // R3: a locked read of the access register shows its FP field as zero.
    p_acc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_locked && rd_sel == 2'd0) |-> ((rd_data & ACC_MASK) == '0));

    // R5: a locked read of the hyp trap register shows its FP field as ones.
    p_hyp_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_locked && rd_sel == 2'd1) |-> ((rd_data & HYP_MASK) == HYP_MASK));

    // R8: at the monitor level, the lock never raises a trap.
    p_mon_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl == 2'd3) |-> (trap_lvl == base_trap_lvl));

    // R7: select 3 reads as zero.
    p_none_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> (rd_data == '0));

    // R11: the raw hyp register value is visible whenever no lock applies.
    p_hyp_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_locked && rd_sel == 2'd1) |-> (rd_data == hyp_raw));
endmodule

// File: tb/sim_fpu_gate_regs.sv
// Directed bench: one task per scenario, and each task checks its own results.
module sim_fpu_gate_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [1:0]  cur_lvl = 2'd1;
    logic        sec_ns = 1'b0;
    logic        mon_present = 1'b1;
    logic        mon_is_64 = 1'b0;
    logic [1:0]  base_trap_lvl = 2'd0;
    logic [1:0]  trap_lvl;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    fpu_gate_regs u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .rd_sel (rd_sel), .rd_data (rd_data),
        .cur_lvl (cur_lvl), .sec_ns (sec_ns), .mon_present (mon_present),
        .mon_is_64 (mon_is_64), .base_trap_lvl (base_trap_lvl), .trap_lvl (trap_lvl)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Set the security view on a falling edge; nothing is written.
    task automatic set_view(input logic ns, input logic [1:0] lvl);
        @(negedge clk);
        sec_ns  = ns;
        cur_lvl = lvl;
    endtask

    // One-cycle write using the present security view.
    task automatic do_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        @(negedge clk);
        rd_sel = sel;
        #1 check32(req, rd_data, exp);
    endtask

    task automatic trap_chk(input string req, input logic [1:0] lvl, input logic ns,
                            input logic [1:0] base, input logic [1:0] exp);
        @(negedge clk);
        cur_lvl = lvl; sec_ns = ns; base_trap_lvl = base;
        #1 check32(req, {30'd0, trap_lvl}, {30'd0, exp});
    endtask

    task automatic t_reset;
        set_view(1'b0, 2'd3);
        read_chk("R7", 2'd0, 32'h0);
        read_chk("R7", 2'd1, 32'h0);
        read_chk("R7", 2'd2, 32'h0);
        read_chk("R7", 2'd3, 32'h0);
        trap_chk("R2", 2'd1, 1'b1, 2'd0, 2'd1);
    endtask

    task automatic t_secure_and_masked_read;
        set_view(1'b0, 2'd1);
        do_write(2'd0, 32'h00F0_0ABC);
        do_write(2'd1, 32'h0000_0005);
        read_chk("R10", 2'd0, 32'h00F0_0ABC);
        read_chk("R10", 2'd1, 32'h0000_0005);
        set_view(1'b1, 2'd1);
        read_chk("R3", 2'd0, 32'h0000_0ABC);
        read_chk("R5", 2'd1, 32'h0000_0C05);
    endtask

    task automatic t_masked_write;
        set_view(1'b1, 2'd2);
        do_write(2'd0, 32'h0000_1234);
        do_write(2'd1, 32'hFFFF_FFFF);
        set_view(1'b0, 2'd3);
        read_chk("R4", 2'd0, 32'h00F0_1234);
        read_chk("R6", 2'd1, 32'hFFFF_F3FF);
    endtask

    task automatic t_strap_off;
        set_view(1'b1, 2'd1);
        @(negedge clk); mon_is_64 = 1'b1;
        read_chk("R1", 2'd0, 32'h00F0_1234);
        trap_chk("R1", 2'd1, 1'b1, 2'd3, 2'd3);
        @(negedge clk); mon_is_64 = 1'b0; mon_present = 1'b0;
        read_chk("R1", 2'd1, 32'hFFFF_F3FF);
        trap_chk("R1", 2'd0, 1'b1, 2'd0, 2'd0);
        @(negedge clk); mon_present = 1'b1;
    endtask

    task automatic t_trap;
        trap_chk("R8", 2'd2, 1'b1, 2'd0, 2'd2);
        trap_chk("R8", 2'd0, 1'b1, 2'd0, 2'd1);
        trap_chk("R9", 2'd1, 1'b1, 2'd3, 2'd1);
        trap_chk("R8", 2'd3, 1'b1, 2'd2, 2'd2);
        trap_chk("R9", 2'd1, 1'b0, 2'd2, 2'd2);
    endtask

    task automatic t_retain_and_timing;
        set_view(1'b0, 2'd3);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0000_0400;
        rd_sel = 2'd2;
        #1 check32("R12", rd_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check32("R12", rd_data, 32'h0000_0400);
        set_view(1'b1, 2'd1);
        read_chk("R11", 2'd0, 32'h00F0_1234);
        read_chk("R11", 2'd1, 32'hFFFF_F3FF);
        trap_chk("R2", 2'd1, 1'b1, 2'd0, 2'd0);
        do_write(2'd0, 32'h0000_0001);
        read_chk("R2", 2'd0, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_secure_and_masked_read();
        t_masked_write();
        t_strap_off();
        t_trap();
        t_retain_and_timing();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule